// File: doc/BRIEF.md
# Extended Accumulator Register File

This block holds the programmer-visible registers of an 8-bit processor core that has been widened with two extra byte accumulators, a reset-immune 16-bit value register, a hardwired zero entry and a mode/status byte. The four byte accumulators can also be reached as two 16-bit pairs or as one 32-bit quad. The index registers, stack pointers, program counter, condition byte and page byte are kept here as plain entries, so that the execution unit can read and write all of them through one uniform path.

Two combinational read ports and one clocked write port each take a 4-bit register code and a 2-bit access size. Size `00` is byte, `01` is word, and `1x` is quad. An instruction decoder supplies code and size. When an operand of a transfer has a different width from the other operand, the decoder requests word size, and the block widens a byte accumulator to its pair. Two trap inputs record an illegal opcode or a zero divisor in sticky status bits of the mode byte. Two outputs present the execution mode and the fast-interrupt policy to the rest of the core.

Top module: `xregfile_top`

## Requirements
- R1: Register codes are 0 D, 1 X, 2 Y, 3 U, 4 S, 5 PC, 6 W, 7 V, 8 A, 9 B, 10 CC, 11 DP, 12 zero, 13 MD, 14 E and 15 F. D reads as {A,B}, W reads as {E,F}, and a quad-size read returns {A,B,E,F} with A in bits 31:24, whatever the code. Reads are combinational from the current register state.
- R2: A quad-size write loads A, B, E and F from bits 31:24, 23:16, 15:8 and 7:0 of the write data at one clock edge. A word write to D or W loads both bytes of that pair.
- R3: At word size, the codes A and B both mean D, and the codes E and F both mean W, for reads and for writes. At byte size, each of these codes reaches only its own accumulator, through data bits 7:0.
- R4: A 16-bit code (0 to 7) gives its full 16 bits at byte or word size, zero-extended to 32. The CC, DP and MD bytes read zero-extended at either size. A write to CC or DP takes data bits 7:0.
- R5: The zero code reads 0 at byte and word size. A write to it changes no register.
- R6: V has no reset. Its contents survive an asserted `rstN`.
- R7: While `rstN` is low at a clock edge, every register except V clears to 0, including all bits of MD.
- R8: A write to MD changes only bit 0 (native mode, driven on `nativeMode`) and bit 1 (fast interrupt handled like a normal one, driven on `firqAsIrq`). MD bits 2 to 5 always read 0.
- R9: `trapIllegal` high at an edge sets MD bit 6, and `trapDivZero` high at an edge sets MD bit 7. Both bits stay set until reset, and writes to MD cannot clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| rdCode | input | RD_PORTS x 4 | Register code per read port |
| rdSize | input | RD_PORTS x 2 | Access size per read port |
| rdData | output | RD_PORTS x 32 | Read data per port, zero-extended |
| wrEn | input | 1 | Write enable |
| wrCode | input | 4 | Register code of the write |
| wrSize | input | 2 | Access size of the write |
| wrData | input | 32 | Write data |
| trapIllegal | input | 1 | Sets the illegal-opcode status bit |
| trapDivZero | input | 1 | Sets the zero-divisor status bit |
| nativeMode | output | 1 | MD bit 0 |
| firqAsIrq | output | 1 | MD bit 1 |

## Verification
The bench builds the block with the default of two read ports. This lets every vector write one register and then read two different views of the same bytes in the same cycle, for example the quad view next to a byte view, or a pair view next to its widened accumulator code. With both ports active, the bench can show that a write through one alias is seen through another alias, and that a write to the zero code leaves the quad view unchanged.

// File: rtl/xregfile_pkg.sv
package xregfile_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int QUAD_W = 4 * BYTE_W;
  localparam int CODE_W = 4;
  localparam int SIZE_W = 2;
  localparam int N_WIDE = 5;  // X, Y, U, S, PC

  localparam logic [CODE_W-1:0] C_D    = 4'd0;
  localparam logic [CODE_W-1:0] C_X    = 4'd1;
  localparam logic [CODE_W-1:0] C_Y    = 4'd2;
  localparam logic [CODE_W-1:0] C_U    = 4'd3;
  localparam logic [CODE_W-1:0] C_S    = 4'd4;
  localparam logic [CODE_W-1:0] C_PC   = 4'd5;
  localparam logic [CODE_W-1:0] C_W    = 4'd6;
  localparam logic [CODE_W-1:0] C_V    = 4'd7;
  localparam logic [CODE_W-1:0] C_A    = 4'd8;
  localparam logic [CODE_W-1:0] C_B    = 4'd9;
  localparam logic [CODE_W-1:0] C_CC   = 4'd10;
  localparam logic [CODE_W-1:0] C_DP   = 4'd11;
  localparam logic [CODE_W-1:0] C_ZERO = 4'd12;
  localparam logic [CODE_W-1:0] C_MD   = 4'd13;
  localparam logic [CODE_W-1:0] C_E    = 4'd14;
  localparam logic [CODE_W-1:0] C_F    = 4'd15;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 2'b00;

  typedef enum logic [1:0] {LANE_BYTE = 2'd0, LANE_PAIR = 2'd1, LANE_QUAD = 2'd2} laneSel_e;

  typedef enum logic [4:0] {
    SRC_ZERO, SRC_A, SRC_B, SRC_E, SRC_F, SRC_D, SRC_W, SRC_Q,
    SRC_X, SRC_Y, SRC_U, SRC_S, SRC_PC, SRC_V, SRC_CC, SRC_DP, SRC_MD
  } srcSel_e;

  typedef struct packed {
    logic              a;
    logic              b;
    logic              e;
    logic              f;
    logic              v;
    logic [N_WIDE-1:0] wide;
    logic              cc;
    logic              dp;
    logic              md;
    laneSel_e          lane;
  } wrStrobe_t;
endpackage

// File: rtl/xregfile_ctrl.sv
module xregfile_ctrl
  import xregfile_pkg::*;
#(
  parameter int RD_PORTS = 2
) (
  input  logic                            wrEn,
  input  logic [CODE_W-1:0]               wrCode,
  input  logic [SIZE_W-1:0]               wrSize,
  input  logic [RD_PORTS-1:0][CODE_W-1:0] rdCode,
  input  logic [RD_PORTS-1:0][SIZE_W-1:0] rdSize,
  output wrStrobe_t                       wrStrb,
  output srcSel_e                         rdSel [RD_PORTS]
);

  function automatic srcSel_e decodeRead(input logic [CODE_W-1:0] code,
                                         input logic [SIZE_W-1:0] size);
    srcSel_e sel;
    if (size[1]) begin
      sel = SRC_Q;
    end else begin
      unique case (code)
        C_D:     sel = SRC_D;
        C_X:     sel = SRC_X;
        C_Y:     sel = SRC_Y;
        C_U:     sel = SRC_U;
        C_S:     sel = SRC_S;
        C_PC:    sel = SRC_PC;
        C_W:     sel = SRC_W;
        C_V:     sel = SRC_V;
        C_A:     sel = (size == SZ_BYTE) ? SRC_A : SRC_D;
        C_B:     sel = (size == SZ_BYTE) ? SRC_B : SRC_D;
        C_E:     sel = (size == SZ_BYTE) ? SRC_E : SRC_W;
        C_F:     sel = (size == SZ_BYTE) ? SRC_F : SRC_W;
        C_CC:    sel = SRC_CC;
        C_DP:    sel = SRC_DP;
        C_MD:    sel = SRC_MD;
        default: sel = SRC_ZERO;
      endcase
    end
    return sel;
  endfunction

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rdDec
    assign rdSel[p] = decodeRead(rdCode[p], rdSize[p]);
  end

  logic byteAcc;
  assign byteAcc = (wrSize == SZ_BYTE);

  always_comb begin
    wrStrb = '0;
    wrStrb.lane = wrSize[1] ? LANE_QUAD : (byteAcc ? LANE_BYTE : LANE_PAIR);
    if (wrEn) begin
      if (wrSize[1]) begin
        wrStrb.a = 1'b1;
        wrStrb.b = 1'b1;
        wrStrb.e = 1'b1;
        wrStrb.f = 1'b1;
      end else begin
        unique case (wrCode)
          C_D:  begin wrStrb.a = 1'b1; wrStrb.b = 1'b1; wrStrb.lane = LANE_PAIR; end
          C_W:  begin wrStrb.e = 1'b1; wrStrb.f = 1'b1; wrStrb.lane = LANE_PAIR; end
          C_A:  begin wrStrb.a = 1'b1; wrStrb.b = !byteAcc; end
          C_B:  begin wrStrb.b = 1'b1; wrStrb.a = !byteAcc; end
          C_E:  begin wrStrb.e = 1'b1; wrStrb.f = !byteAcc; end
          C_F:  begin wrStrb.f = 1'b1; wrStrb.e = !byteAcc; end
          C_X:  wrStrb.wide[0] = 1'b1;
          C_Y:  wrStrb.wide[1] = 1'b1;
          C_U:  wrStrb.wide[2] = 1'b1;
          C_S:  wrStrb.wide[3] = 1'b1;
          C_PC: wrStrb.wide[4] = 1'b1;
          C_V:  wrStrb.v = 1'b1;
          C_CC: wrStrb.cc = 1'b1;
          C_DP: wrStrb.dp = 1'b1;
          C_MD: wrStrb.md = 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/xregfile_dp.sv
module xregfile_dp
  import xregfile_pkg::*;
#(
  parameter int RD_PORTS = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  wrStrobe_t                       wrStrb,
  input  logic [QUAD_W-1:0]               wrData,
  input  logic                            trapIllegal,
  input  logic                            trapDivZero,
  input  srcSel_e                         rdSel [RD_PORTS],
  output logic [RD_PORTS-1:0][QUAD_W-1:0] rdData,
  output logic                            nativeMode,
  output logic                            firqAsIrq
);

  logic [BYTE_W-1:0] accA, accB, accE, accF, ccReg, dpReg;
  logic [WORD_W-1:0] vReg;
  logic [WORD_W-1:0] wideReg [N_WIDE];
  logic mdNative, mdFirq, mdIll, mdDiv;

  logic [BYTE_W-1:0] laneA, laneB, laneE, laneF;
  always_comb begin
    unique case (wrStrb.lane)
      LANE_QUAD: begin
        laneA = wrData[4*BYTE_W-1:3*BYTE_W];
        laneB = wrData[3*BYTE_W-1:2*BYTE_W];
        laneE = wrData[2*BYTE_W-1:BYTE_W];
      end
      LANE_PAIR: begin
        laneA = wrData[2*BYTE_W-1:BYTE_W];
        laneB = wrData[BYTE_W-1:0];
        laneE = wrData[2*BYTE_W-1:BYTE_W];
      end
      default: begin
        laneA = wrData[BYTE_W-1:0];
        laneB = wrData[BYTE_W-1:0];
        laneE = wrData[BYTE_W-1:0];
      end
    endcase
    laneF = wrData[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accA <= '0; accB <= '0; accE <= '0; accF <= '0;
      ccReg <= '0; dpReg <= '0;
      mdNative <= 1'b0; mdFirq <= 1'b0; mdIll <= 1'b0; mdDiv <= 1'b0;
    end else begin
      if (wrStrb.a)  accA  <= laneA;
      if (wrStrb.b)  accB  <= laneB;
      if (wrStrb.e)  accE  <= laneE;
      if (wrStrb.f)  accF  <= laneF;
      if (wrStrb.cc) ccReg <= wrData[BYTE_W-1:0];
      if (wrStrb.dp) dpReg <= wrData[BYTE_W-1:0];
      if (wrStrb.md) begin
        mdNative <= wrData[0];
        mdFirq   <= wrData[1];
      end
      if (trapIllegal) mdIll <= 1'b1;
      if (trapDivZero) mdDiv <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    always_ff @(posedge clk) begin
      if (!rstN)                wideReg[i] <= '0;
      else if (wrStrb.wide[i])  wideReg[i] <= wrData[WORD_W-1:0];
    end
  end

  // Value register: deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    if (wrStrb.v) vReg <= wrData[WORD_W-1:0];
  end

  logic [BYTE_W-1:0] mdView;
  always_comb begin
    mdView    = '0;
    mdView[0] = mdNative;
    mdView[1] = mdFirq;
    mdView[6] = mdIll;
    mdView[7] = mdDiv;
  end

  function automatic logic [QUAD_W-1:0] pick(input srcSel_e sel);
    unique case (sel)
      SRC_A:   return QUAD_W'(accA);
      SRC_B:   return QUAD_W'(accB);
      SRC_E:   return QUAD_W'(accE);
      SRC_F:   return QUAD_W'(accF);
      SRC_D:   return QUAD_W'({accA, accB});
      SRC_W:   return QUAD_W'({accE, accF});
      SRC_Q:   return {accA, accB, accE, accF};
      SRC_X:   return QUAD_W'(wideReg[0]);
      SRC_Y:   return QUAD_W'(wideReg[1]);
      SRC_U:   return QUAD_W'(wideReg[2]);
      SRC_S:   return QUAD_W'(wideReg[3]);
      SRC_PC:  return QUAD_W'(wideReg[4]);
      SRC_V:   return QUAD_W'(vReg);
      SRC_CC:  return QUAD_W'(ccReg);
      SRC_DP:  return QUAD_W'(dpReg);
      SRC_MD:  return QUAD_W'(mdView);
      default: return '0;
    endcase
  endfunction

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdData[p] = pick(rdSel[p]);
  end

  assign nativeMode = mdNative;
  assign firqAsIrq  = mdFirq;

  // ---------------- assertions ----------------
  assert_quad_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrStrb.a && wrStrb.b && wrStrb.e && wrStrb.f && wrStrb.lane == LANE_QUAD))
    |-> ({accA, accB, accE, accF} == $past(wrData)));

  assert_trap_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(trapIllegal)) |-> (mdIll && !$past(trapDivZero) || mdIll));

  assert_div_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(trapDivZero)) |-> mdDiv);

  assert_trap_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(mdIll)) |-> mdIll);

  logic vKnown = 1'b0;
  always_ff @(posedge clk) if (wrStrb.v) vKnown <= 1'b1;

  assert_v_hold_R6: assert property (@(posedge clk)
    ($past(vKnown) && !$past(wrStrb.v)) |-> (vReg == $past(vReg)));

endmodule

// File: rtl/xregfile_top.sv
module xregfile_top
  import xregfile_pkg::*;
#(
  parameter int RD_PORTS = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [RD_PORTS-1:0][3:0]        rdCode,
  input  logic [RD_PORTS-1:0][1:0]        rdSize,
  output logic [RD_PORTS-1:0][31:0]       rdData,
  input  logic                            wrEn,
  input  logic [3:0]                      wrCode,
  input  logic [1:0]                      wrSize,
  input  logic [31:0]                     wrData,
  input  logic                            trapIllegal,
  input  logic                            trapDivZero,
  output logic                            nativeMode,
  output logic                            firqAsIrq
);

  wrStrobe_t wrStrb;
  srcSel_e   rdSel [RD_PORTS];

  xregfile_ctrl #(.RD_PORTS(RD_PORTS)) i_ctrl (
    .wrEn   (wrEn),
    .wrCode (wrCode),
    .wrSize (wrSize),
    .rdCode (rdCode),
    .rdSize (rdSize),
    .wrStrb (wrStrb),
    .rdSel  (rdSel)
  );

  xregfile_dp #(.RD_PORTS(RD_PORTS)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrStrb      (wrStrb),
    .wrData      (wrData),
    .trapIllegal (trapIllegal),
    .trapDivZero (trapDivZero),
    .rdSel       (rdSel),
    .rdData      (rdData),
    .nativeMode  (nativeMode),
    .firqAsIrq   (firqAsIrq)
  );

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_chk
    assert_zero_reads_R5: assert property (@(posedge clk) disable iff (!rstN)
      (rdCode[p] == C_ZERO && !rdSize[p][1]) |-> (rdData[p] == '0));

    assert_md_unused_R8: assert property (@(posedge clk) disable iff (!rstN)
      (rdCode[p] == C_MD && !rdSize[p][1]) |-> (rdData[p][31:8] == '0 && rdData[p][5:2] == '0));
  end

  assert_md_outputs_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrEn)) |-> ($stable(nativeMode) && $stable(firqAsIrq)));

endmodule

// File: tb/test_xregfile_top.sv
module test_xregfile_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic             rstN;
  logic [1:0][3:0]  rdCode;
  logic [1:0][1:0]  rdSize;
  logic [1:0][31:0] rdData;
  logic             wrEn;
  logic [3:0]       wrCode;
  logic [1:0]       wrSize;
  logic [31:0]      wrData;
  logic             trapIllegal, trapDivZero;
  logic             nativeMode, firqAsIrq;

  xregfile_top i_xregfile_top (
    .clk(clk), .rstN(rstN), .rdCode(rdCode), .rdSize(rdSize), .rdData(rdData),
    .wrEn(wrEn), .wrCode(wrCode), .wrSize(wrSize), .wrData(wrData),
    .trapIllegal(trapIllegal), .trapDivZero(trapDivZero),
    .nativeMode(nativeMode), .firqAsIrq(firqAsIrq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic        we;
    logic [3:0]  wc;
    logic [1:0]  ws;
    logic [31:0] wd;
    logic [3:0]  c0;
    logic [1:0]  s0;
    logic [31:0] e0;
    logic [3:0]  c1;
    logic [1:0]  s1;
    logic [31:0] e1;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R2 quad write, byte reads of A and F
    '{1'b1, 4'd0,  2'b10, 32'h11223344, 4'd8,  2'b00, 32'h11,       4'd15, 2'b00, 32'h44,       8'd2},
    // R1 pair views
    '{1'b0, 4'd0,  2'b00, 32'h0,        4'd0,  2'b01, 32'h1122,     4'd6,  2'b01, 32'h3344,     8'd1},
    // R3 word write via A code updates D
    '{1'b1, 4'd8,  2'b01, 32'h0000AABB, 4'd0,  2'b10, 32'hAABB3344, 4'd9,  2'b00, 32'hBB,       8'd3},
    // R3 byte write to F only
    '{1'b1, 4'd15, 2'b00, 32'h000000CD, 4'd6,  2'b01, 32'h33CD,     4'd14, 2'b01, 32'h33CD,     8'd3},
    // R5 write to zero code
    '{1'b1, 4'd12, 2'b01, 32'h0000FFFF, 4'd12, 2'b01, 32'h0,        4'd0,  2'b10, 32'hAABB33CD, 8'd5},
    // R4 V at byte size is full 16 bits; R1 quad ignores code
    '{1'b1, 4'd7,  2'b01, 32'h00005A5A, 4'd7,  2'b00, 32'h5A5A,     4'd12, 2'b10, 32'hAABB33CD, 8'd4},
    // R4 16-bit code keeps low 16 bits
    '{1'b1, 4'd1,  2'b01, 32'hFFFF1234, 4'd1,  2'b01, 32'h1234,     4'd10, 2'b00, 32'h0,        8'd4},
    // R8 MD write keeps only bits 1:0
    '{1'b1, 4'd13, 2'b00, 32'h000000FF, 4'd13, 2'b00, 32'h03,       4'd10, 2'b01, 32'h0,        8'd8},
    // R4 CC takes low byte, zero-extended at word size
    '{1'b1, 4'd10, 2'b01, 32'h00001E5A, 4'd10, 2'b01, 32'h5A,       4'd11, 2'b00, 32'h0,        8'd4},
    // R8 MD rewrite
    '{1'b1, 4'd13, 2'b00, 32'h00000002, 4'd13, 2'b01, 32'h02,       4'd5,  2'b01, 32'h0,        8'd8},
    // R3 word write via E code updates W
    '{1'b1, 4'd14, 2'b01, 32'h00009876, 4'd6,  2'b01, 32'h9876,     4'd15, 2'b00, 32'h76,       8'd3},
    // R2 word write to D
    '{1'b1, 4'd0,  2'b01, 32'h0000C3D4, 4'd8,  2'b00, 32'hC3,       4'd0,  2'b10, 32'hC3D49876, 8'd2}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readBoth(input logic [3:0] c0, input logic [1:0] s0,
                          input logic [3:0] c1, input logic [1:0] s1);
    rdCode[0] = c0; rdSize[0] = s0;
    rdCode[1] = c1; rdSize[1] = s1;
    #1;
  endtask

  task automatic doWrite(input logic [3:0] c, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrCode = c; wrSize = s; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic pulseTrap(input bit ill, input bit dz);
    @(negedge clk);
    trapIllegal = ill; trapDivZero = dz;
    @(posedge clk);
    #1 trapIllegal = 1'b0; trapDivZero = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrCode = '0; wrSize = '0; wrData = '0;
    trapIllegal = 1'b0; trapDivZero = 1'b0; rdCode = '0; rdSize = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R7 reset state
    readBoth(4'd0, 2'b10, 4'd13, 2'b00);
    check("R7 quad after reset", rdData[0], 32'h0);
    check("R7 MD after reset", rdData[1], 32'h0);
    readBoth(4'd1, 2'b01, 4'd10, 2'b00);
    check("R7 X after reset", rdData[0], 32'h0);
    check("R7 CC after reset", rdData[1], 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) doWrite(VECS[i].wc, VECS[i].ws, VECS[i].wd);
      else @(negedge clk);
      readBoth(VECS[i].c0, VECS[i].s0, VECS[i].c1, VECS[i].s1);
      check($sformatf("R%0d vector %0d port0", VECS[i].req, i), rdData[0], VECS[i].e0);
      check($sformatf("R%0d vector %0d port1", VECS[i].req, i), rdData[1], VECS[i].e1);
      if (i == 7) begin
        check("R8 nativeMode", {31'b0, nativeMode}, 32'h1);
        check("R8 firqAsIrq", {31'b0, firqAsIrq}, 32'h1);
      end
    end

    // R9 traps set status bits and survive MD writes
    pulseTrap(1'b1, 1'b0);
    readBoth(4'd13, 2'b00, 4'd13, 2'b01);
    check("R9 illegal trap", rdData[0], 32'h42);
    doWrite(4'd13, 2'b00, 32'h000000C1);
    readBoth(4'd13, 2'b00, 4'd0, 2'b00);
    check("R9 write keeps trap bit", rdData[0], 32'h41);
    pulseTrap(1'b0, 1'b1);
    readBoth(4'd13, 2'b00, 4'd0, 2'b00);
    check("R9 divide trap", rdData[0], 32'hC1);
    check("R8 nativeMode set", {31'b0, nativeMode}, 32'h1);
    check("R8 firqAsIrq cleared", {31'b0, firqAsIrq}, 32'h0);

    // R6 / R7 reset clears all but V
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    readBoth(4'd7, 2'b01, 4'd13, 2'b00);
    check("R6 V kept through reset", rdData[0], 32'h5A5A);
    check("R7 MD cleared", rdData[1], 32'h0);
    readBoth(4'd0, 2'b10, 4'd1, 2'b01);
    check("R7 quad cleared", rdData[0], 32'h0);
    check("R7 X cleared", rdData[1], 32'h0);
    check("R7 nativeMode cleared", {31'b0, nativeMode}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule